// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces one data-RAM address per cycle for filter kernels that walk circular delay lines. It holds a pointer register and a signed step register. Each cycle it runs one opcode, drives an address taken from the registers' current values, and updates the pointer for the next cycle. Because the pointer moves around a ring instead of the samples being copied, an FIR or IIR tap loop keeps up with one tap per clock.

The ring size is a power of two and is set by a mask register, which holds contiguous ones in its low bits. Only the pointer bits under the mask change. The bits above the mask are held, so they fix the base of the ring, and the field under the mask wraps on its own without any compare logic. The pointer can step by +1, by -1, or by the signed step register. A reverse-carry step adds the step register with carries moving from the top of the field toward bit 0, which walks the ring in bit-reversed order for FFT data. A host loads the pointer, the step and the mask through a strobe-qualified data port. A load takes priority over the opcode in the same cycle.

Top module: `modaddr_unit`

## Requirements
- R1: After reset the pointer is 0, the step is 0 and the mask is all ones, so the whole address range forms one ring. `addr_o` reads 0 under opcode 0.
- R2: `addr_o` shows the pointer for every opcode except opcode 1, which shows the step register. The value shown is the one held before the edge, and any update is visible from the next cycle.
- R3: Opcodes 0 and 1 leave the pointer and step unchanged, and so does the spare opcode 7.
- R4: Opcode 2 adds 1 to the pointer bits selected by the mask, wrapping from all-ones to zero, and holds every pointer bit outside the mask.
- R5: Opcode 3 subtracts 1 from the masked pointer field, wrapping from zero to all-ones, and holds the unmasked bits.
- R6: Opcode 4 adds the signed step to the masked pointer field modulo the ring size, so a negative step wraps backward correctly. The unmasked bits are held.
- R7: Opcode 5 increments the step register by 1 and leaves the pointer unchanged.
- R8: Opcode 6 adds the masked step to the masked pointer field with carries moving from the field's most significant bit toward bit 0. The carry out of bit 0 is dropped and the unmasked bits are held. With an 8-entry ring and a step of 4, the field visits 0,4,2,6,1,5,3,7.
- R9: When `ld_ptr_i`, `ld_step_i` or `ld_mask_i` is high, the selected register takes `ld_data_i` at that edge. While any load strobe is high the opcode changes no register.
- R10: With base 16, mask 7, pointer 17 and step -2, the opcode sequence 0,2,2,2,2,4,3 produces the addresses 17,17,18,19,20,21,19 and leaves the pointer at 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ptr_i | input | 1 | Load the pointer from ld_data_i |
| ld_step_i | input | 1 | Load the step from ld_data_i |
| ld_mask_i | input | 1 | Load the ring mask from ld_data_i |
| ld_data_i | input | AW (16) | Data for the load strobes |
| op_i | input | 3 | Opcode executed this cycle |
| addr_o | output | AW (16) | Address for the RAM |

## Verification
A wrong pointer becomes visible on `addr_o` in the first cycle after the faulty update. For example, a carry that leaks out of the masked field changes the ring base, and a bit-reversed step with its carry in the wrong direction produces the wrong visiting order. The bench compares `addr_o` with its model in every cycle, so any pointer error shows up in the next cycle. An error in the step register stays hidden until a step opcode uses it or opcode 1 reads it. Because the random opcode mix includes opcode 1 often, the bench exposes such an error within a few cycles.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

   localparam int unsigned OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_READ_A   = 3'd0,
      OP_READ_S   = 3'd1,
      OP_INC_A    = 3'd2,
      OP_DEC_A    = 3'd3,
      OP_STEP     = 3'd4,
      OP_INC_STEP = 3'd5,
      OP_STEP_REV = 3'd6,
      OP_SPARE    = 3'd7
   } modaddr_op_e;

endpackage

// File: rtl/modaddr_revadd.sv
module modaddr_revadd #(
   parameter int unsigned AW = 16
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   input  logic [AW-1:0] mask_i,
   output logic [AW-1:0] sum_o
);
   logic [AW-1:0] a_m, b_m, a_r, b_r, s_r, s_n;

   assign a_m = a_i & mask_i;
   assign b_m = b_i & mask_i;

   // Mirror the operands so the field's top bit becomes the adder's low end.
   for (genvar i = 0; i < AW; i++) begin : g_mirror_in
      assign a_r[i] = a_m[AW-1-i];
      assign b_r[i] = b_m[AW-1-i];
   end

   assign s_r = a_r + b_r;

   for (genvar i = 0; i < AW; i++) begin : g_mirror_out
      assign s_n[i] = s_r[AW-1-i];
   end

   assign sum_o = s_n & mask_i;
endmodule

// File: rtl/modaddr_next.sv
module modaddr_next
   import modaddr_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter bit          BITREV_EN = 1'b1
) (
   input  logic [AW-1:0] ptr_i,
   input  logic [AW-1:0] step_i,
   input  logic [AW-1:0] mask_i,
   input  modaddr_op_e   op_i,
   output logic [AW-1:0] ptr_nxt_o,
   output logic          ptr_we_o,
   output logic [AW-1:0] step_nxt_o,
   output logic          step_we_o
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] lin_raw;
   logic [AW-1:0] rev_raw;
   logic [AW-1:0] field_raw;

   always_comb begin
      unique case (op_i)
         OP_INC_A: lin_raw = ptr_i + ONE;
         OP_DEC_A: lin_raw = ptr_i - ONE;
         OP_STEP:  lin_raw = ptr_i + step_i;
         default:  lin_raw = ptr_i;
      endcase
   end

   if (BITREV_EN) begin : g_rev
      modaddr_revadd #(.AW(AW)) revadd_i (
         .a_i   (ptr_i),
         .b_i   (step_i),
         .mask_i(mask_i),
         .sum_o (rev_raw)
      );
   end else begin : g_norev
      assign rev_raw = ptr_i;
   end

   assign field_raw = (op_i == OP_STEP_REV) ? rev_raw : lin_raw;

   // Upper bits keep the ring base; only the masked field takes the new value.
   assign ptr_nxt_o = (ptr_i & ~mask_i) | (field_raw & mask_i);

   always_comb begin
      unique case (op_i)
         OP_INC_A, OP_DEC_A, OP_STEP: ptr_we_o = 1'b1;
         OP_STEP_REV:                 ptr_we_o = BITREV_EN;
         default:                     ptr_we_o = 1'b0;
      endcase
   end

   assign step_nxt_o = step_i + ONE;
   assign step_we_o  = (op_i == OP_INC_STEP);
endmodule

// File: rtl/modaddr_regs.sv
module modaddr_regs #(
   parameter int unsigned AW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ld_ptr_i,
   input  logic          ld_step_i,
   input  logic          ld_mask_i,
   input  logic [AW-1:0] ld_data_i,
   input  logic          ptr_we_i,
   input  logic [AW-1:0] ptr_nxt_i,
   input  logic          step_we_i,
   input  logic [AW-1:0] step_nxt_i,
   output logic [AW-1:0] ptr_q_o,
   output logic [AW-1:0] step_q_o,
   output logic [AW-1:0] mask_q_o
);
   logic any_ld;
   assign any_ld = ld_ptr_i | ld_step_i | ld_mask_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q_o  <= '0;
         step_q_o <= '0;
         mask_q_o <= '1;
      end else begin
         if (ld_ptr_i)                   ptr_q_o  <= ld_data_i;
         else if (!any_ld && ptr_we_i)   ptr_q_o  <= ptr_nxt_i;
         if (ld_step_i)                  step_q_o <= ld_data_i;
         else if (!any_ld && step_we_i)  step_q_o <= step_nxt_i;
         if (ld_mask_i)                  mask_q_o <= ld_data_i;
      end
   end
endmodule

// File: rtl/modaddr_unit.sv
module modaddr_unit
   import modaddr_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter bit          BITREV_EN = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            ld_ptr_i,
   input  logic            ld_step_i,
   input  logic            ld_mask_i,
   input  logic [AW-1:0]   ld_data_i,
   input  logic [OP_W-1:0] op_i,
   output logic [AW-1:0]   addr_o
);
   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("modaddr_unit: AW must lie in 2..32");
   end

   modaddr_op_e   op;
   logic [AW-1:0] ptr_q, step_q, mask_q;
   logic [AW-1:0] ptr_nxt, step_nxt;
   logic          ptr_we, step_we;

   assign op = modaddr_op_e'(op_i);

   modaddr_next #(.AW(AW), .BITREV_EN(BITREV_EN)) next_i (
      .ptr_i     (ptr_q),
      .step_i    (step_q),
      .mask_i    (mask_q),
      .op_i      (op),
      .ptr_nxt_o (ptr_nxt),
      .ptr_we_o  (ptr_we),
      .step_nxt_o(step_nxt),
      .step_we_o (step_we)
   );

   modaddr_regs #(.AW(AW)) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_ptr_i  (ld_ptr_i),
      .ld_step_i (ld_step_i),
      .ld_mask_i (ld_mask_i),
      .ld_data_i (ld_data_i),
      .ptr_we_i  (ptr_we),
      .ptr_nxt_i (ptr_nxt),
      .step_we_i (step_we),
      .step_nxt_i(step_nxt),
      .ptr_q_o   (ptr_q),
      .step_q_o  (step_q),
      .mask_q_o  (mask_q)
   );

   assign addr_o = (op == OP_READ_S) ? step_q : ptr_q;
endmodule

// File: rtl/modaddr_chk.sv
module modaddr_chk #(
   parameter int unsigned AW = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          ld_ptr_i,
   input logic          ld_step_i,
   input logic          ld_mask_i,
   input logic [AW-1:0] ld_data_i,
   input logic [2:0]    op_i,
   input logic [AW-1:0] ptr_q,
   input logic [AW-1:0] step_q,
   input logic [AW-1:0] mask_q
);
   logic quiet;
   assign quiet = !(ld_ptr_i || ld_step_i || ld_mask_i);

   AST_READ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && (op_i == 3'd0 || op_i == 3'd1 || op_i == 3'd7)) |=> ($stable(ptr_q) && $stable(step_q))); // R3

   AST_INC_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && op_i == 3'd2) |=> (((ptr_q ^ ($past(ptr_q) + AW'(1))) & $past(mask_q)) == '0)); // R4

   AST_DEC_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && op_i == 3'd3) |=> (((ptr_q ^ ($past(ptr_q) - AW'(1))) & $past(mask_q)) == '0)); // R5

   AST_BASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && (op_i == 3'd4 || op_i == 3'd6)) |=> (((ptr_q ^ $past(ptr_q)) & ~$past(mask_q)) == '0)); // R6

   AST_STEP_BUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && op_i == 3'd5) |=> (step_q == $past(step_q) + AW'(1) && $stable(ptr_q))); // R7

   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_ptr_i |=> (ptr_q == $past(ld_data_i))); // R9

   AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ld_mask_i) |=> $stable(mask_q)); // R9
endmodule

bind modaddr_unit modaddr_chk #(.AW(AW)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .ld_ptr_i (ld_ptr_i),
   .ld_step_i(ld_step_i),
   .ld_mask_i(ld_mask_i),
   .ld_data_i(ld_data_i),
   .op_i     (op_i),
   .ptr_q    (ptr_q),
   .step_q   (step_q),
   .mask_q   (mask_q)
);

// File: tb/modaddr_unit_tb_top.sv
`timescale 1ns/1ps
module modaddr_unit_tb_top;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_ptr = 1'b0, ld_step = 1'b0, ld_mask = 1'b0;
   logic [AW-1:0] ld_data = '0;
   logic [2:0]    op = 3'd0;
   logic [AW-1:0] addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [AW-1:0] m_a, m_s, m_m;

   always #2.5 clk = ~clk;

   modaddr_unit #(.AW(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ld_ptr_i(ld_ptr), .ld_step_i(ld_step),
      .ld_mask_i(ld_mask), .ld_data_i(ld_data), .op_i(op), .addr_o(addr)
   );

   function automatic logic [AW-1:0] rev_step(input logic [AW-1:0] a, s, m);
      logic [AW-1:0] r = '0;
      logic c = 1'b0;
      for (int i = AW-1; i >= 0; i--) begin
         if (m[i]) begin
            r[i] = a[i] ^ s[i] ^ c;
            c    = (a[i] & s[i]) | (c & (a[i] ^ s[i]));
         end
      end
      return r;
   endfunction

   function automatic logic [AW-1:0] next_a(input logic [2:0] o, input logic [AW-1:0] a, s, m);
      logic [AW-1:0] f;
      case (o)
         3'd2:    f = a + 1'b1;
         3'd3:    f = a - 1'b1;
         3'd4:    f = a + s;
         3'd6:    f = rev_step(a, s, m);
         default: f = a;
      endcase
      return (a & ~m) | (f & m);
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0, 3'd1: return "R2";
         3'd2:       return "R4";
         3'd3:       return "R5";
         3'd4:       return "R6";
         3'd5:       return "R7";
         3'd6:       return "R8";
         default:    return "R3";
      endcase
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] act, exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s addr_o=%h expected=%h", tag, act, exp);
      end
   endtask

   // Inputs change at the falling edge; the address is checked 1 ns later.
   task automatic cyc(input logic [2:0] o, input logic lp, ls, lm,
                      input logic [AW-1:0] d, input string tag);
      logic any;
      op = o; ld_ptr = lp; ld_step = ls; ld_mask = lm; ld_data = d;
      #1;
      check(tag, addr, (o == 3'd1) ? m_s : m_a);
      @(posedge clk);
      any = lp | ls | lm;
      if (any) begin
         if (lp) m_a = d;
         if (ls) m_s = d;
         if (lm) m_m = d;
      end else begin
         m_a = next_a(o, m_a, m_s, m_m);
         if (o == 3'd5) m_s = m_s + 1'b1;
      end
      @(negedge clk);
      ld_ptr = 1'b0; ld_step = 1'b0; ld_mask = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_a = '0; m_s = '0; m_m = '1;
      repeat (3) @(negedge clk);
      #1;
      check("R1", addr, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: full-width ring after reset.
      cyc(3'd0, 1, 0, 0, 16'hFFFF, "R9");
      cyc(3'd2, 0, 0, 0, 16'h0000, "R1");
      cyc(3'd0, 0, 0, 0, 16'h0000, "R1");

      // R10: worked sequence.
      cyc(3'd0, 1, 1, 1, 16'h0011, "R9");
      cyc(3'd0, 0, 1, 1, 16'h0007, "R9");
      cyc(3'd0, 0, 1, 0, 16'hFFFE, "R9");
      cyc(3'd0, 0, 0, 0, 0, "R10");
      cyc(3'd2, 0, 0, 0, 0, "R10");
      cyc(3'd2, 0, 0, 0, 0, "R10");
      cyc(3'd2, 0, 0, 0, 0, "R10");
      cyc(3'd2, 0, 0, 0, 0, "R10");
      cyc(3'd4, 0, 0, 0, 0, "R10");
      cyc(3'd3, 0, 0, 0, 0, "R10");
      cyc(3'd0, 0, 0, 0, 0, "R10");
      check("R10", m_a, 16'h0012);

      // R4/R5 wrap edges.
      cyc(3'd0, 1, 0, 0, 16'h0017, "R9");
      cyc(3'd2, 0, 0, 0, 0, "R4");
      cyc(3'd3, 0, 0, 0, 0, "R5");
      cyc(3'd0, 0, 0, 0, 0, "R5");

      // R6: negative step wraps backward.
      cyc(3'd0, 1, 1, 0, 16'hFFFD, "R9");
      cyc(3'd0, 1, 0, 0, 16'h0011, "R9");
      cyc(3'd4, 0, 0, 0, 0, "R6");
      cyc(3'd1, 0, 0, 0, 0, "R6");
      cyc(3'd0, 0, 0, 0, 0, "R6");

      // R8: bit-reversed order 0,4,2,6,1,5,3,7 over an 8-entry ring.
      cyc(3'd0, 0, 1, 0, 16'h0004, "R9");
      cyc(3'd0, 1, 0, 0, 16'h0010, "R9");
      for (int i = 0; i < 9; i++) cyc(3'd6, 0, 0, 0, 0, "R8");

      // R7 and R9 priority: load beats opcode.
      cyc(3'd5, 0, 0, 0, 0, "R7");
      cyc(3'd1, 0, 0, 0, 0, "R7");
      cyc(3'd2, 1, 0, 0, 16'h0013, "R9");
      cyc(3'd4, 0, 0, 1, 16'h000F, "R9");
      cyc(3'd7, 0, 0, 0, 0, "R3");
      cyc(3'd0, 0, 0, 0, 0, "R9");

      // Random mix.
      for (int n = 0; n < 4000; n++) begin
         logic [2:0]    o  = 3'($urandom_range(0, 7));
         logic          lp = ($urandom_range(0, 15) == 0);
         logic          ls = ($urandom_range(0, 15) == 0);
         logic          lm = ($urandom_range(0, 19) == 0);
         logic [AW-1:0] d;
         if (lm) begin
            int k = $urandom_range(0, AW);
            d = AW'((17'(1) << k) - 17'(1));
            lp = 1'b0; ls = 1'b0;
         end else begin
            d = AW'($urandom);
         end
         cyc(o, lp, ls, lm, d, (lp | ls | lm) ? "R9" : tag_of(o));
      end

      finish_run();
   end
endmodule